// File: doc/BRIEF.md
# Packet Bus Output Sequencer

This block is the sending side of a device attached to a synchronous 64-bit packet-switched bus. Packets reach it through two internal enqueue ports. The request port takes a two-beat outgoing request into a single-entry buffer, so only one such request is outstanding at a time. The reply port takes a packet of two or five beats, selected by a length tag, into a small FIFO of five-beat slots. The FIFO carries block-data replies, dirty-block flushes and short replies to IO requests.

When a packet is waiting, the sequencer asks the external arbiter for the bus with a two-bit code. The code also tells the arbiter how long the packet is and how urgent it is. After the arbiter grants the bus with a matching length, the sequencer drives the beats one per cycle, starting in the cycle after the grant. It marks the first beat with a header flag and enables the bus drivers only while a packet is on the bus. The FIFO is always served ahead of the request buffer. The producer is expected never to overfill the FIFO. If it does, the block raises a sticky stop line that halts the whole system.

Top module: `pkt_bus_out`

## Requirements
- R1: During and after reset, `arbReq` is 00, `busOutEn`, `headerOut` and `stopOut` are 0, and `busOut` reads all zeros whenever `busOutEn` is 0.
- R2: While a packet is chosen and not yet fully sent, `arbReq` is 11 if it has five beats and 10 if it has two beats. It is 00 when nothing is chosen. The code 01 is never produced.
- R3: A grant is taken only if `longGrant` is 1 for a five-beat packet or 0 for a two-beat packet. A grant with the other length is ignored, and the request code stays as it was.
- R4: After a grant is taken at clock edge G, `busOutEn` is 1 for exactly the packet's length in cycles, starting right after G. `busOut` carries beat 0, 1, ... in that order, where beat i is bits [64*i+63 : 64*i] of the enqueued data.
- R5: `headerOut` is 1 during the first beat of each packet and 0 during every other beat.
- R6: In the cycle after the last beat, `arbReq` returns to 00 and `busOutEn` to 0.
- R7: If both sources are ready when a packet is chosen, the FIFO packet goes first and the buffered request follows.
- R8: FIFO packets leave in the order in which they were enqueued.
- R9: A request enqueue while a request is already pending is dropped and is never sent.
- R10: A reply enqueue while all FIFO slots are full sets `stopOut` and the packet is dropped. `stopOut` then stays 1 until reset.
- R11: `rplLong` = 1 tags a five-beat packet and 0 a two-beat packet. Packets of both lengths may be mixed in the FIFO, and each keeps its own length on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPush | input | 1 | Enqueue a two-beat request |
| reqData | input | 128 | Request beats, beat i at bits 64*i+63:64*i |
| rplPush | input | 1 | Enqueue a packet into the reply FIFO |
| rplLong | input | 1 | 1 = five-beat packet, 0 = two-beat packet |
| rplData | input | 320 | Packet beats, beat i at bits 64*i+63:64*i |
| grant | input | 1 | Arbiter grant: the bus may be used from the next cycle |
| longGrant | input | 1 | Grant is for a five-beat (1) or two-beat (0) packet |
| arbReq | output | 2 | Request code: 00 none, 10 short, 11 long |
| busOut | output | 64 | Data-out beat, zero when not driving |
| busOutEn | output | 1 | Drive enable for busOut |
| headerOut | output | 1 | First beat of a packet |
| stopOut | output | 1 | Sticky system stop on FIFO overflow |

## Verification
An enqueue is captured at one edge, and the packet is chosen at the next edge, so `arbReq` shows the code after two edges. The bench therefore polls for the code before it grants. A grant sampled at edge G makes beat 0 visible just after G, and beat i just after G+i. The bench samples one time unit after each edge and compares every beat in turn. The return of `arbReq` to 00 is checked in the cycle after the last beat. An overflowing enqueue shows `stopOut` right after its own edge. Dropped packets are proven absent by draining the FIFO and watching that no further request code appears.

// File: rtl/pkt_bus_out_pkg.sv
package pkt_bus_out_pkg;
  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic popFifo;   // last beat of a FIFO packet leaves at this edge
    logic popReq;    // last beat of the buffered request leaves at this edge
    logic selFifo;   // beat source: 1 FIFO head, 0 request buffer
    logic drive;     // a beat is on the bus this cycle
    logic header;    // this beat is the first of its packet
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pkt_bus_out_dp.sv
module pkt_bus_out_dp
  import pkt_bus_out_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LONG_LEN  = 5,
  parameter int SHORT_LEN = 2,
  parameter int SLOTS     = 4,
  localparam int IDX_W    = $clog2(LONG_LEN),
  localparam int PTR_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqPush,
  input  logic [SHORT_LEN*DATA_W-1:0]   reqData,
  input  logic                          rplPush,
  input  logic                          rplLong,
  input  logic [LONG_LEN*DATA_W-1:0]    rplData,
  input  strobe_t                       st,
  input  logic [IDX_W-1:0]              beatIdx,
  output logic                          fifoEmpty,
  output logic                          headLong,
  output logic                          reqPending,
  output logic [DATA_W-1:0]             busOut,
  output logic                          stopOut
);
  logic [DATA_W-1:0] slotMem [SLOTS][LONG_LEN];
  logic [SLOTS-1:0]  slotLong;
  logic [DATA_W-1:0] reqMem [SHORT_LEN];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic              fifoFull, doWr, doReq;
  logic [DATA_W-1:0] fifoBeat, reqBeat;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoFull  = (count == CNT_W'(SLOTS));
  assign fifoEmpty = (count == '0);
  assign doWr      = rplPush && !fifoFull;
  assign doReq     = reqPush && !reqPending;
  assign headLong  = slotLong[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      count      <= '0;
      reqPending <= 1'b0;
      stopOut    <= 1'b0;
      slotLong   <= '0;
    end else begin
      if (doWr) begin
        wrPtr           <= bump(wrPtr);
        slotLong[wrPtr] <= rplLong;
      end
      if (st.popFifo) rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(doWr) - CNT_W'(st.popFifo);
      if (rplPush && fifoFull) stopOut <= 1'b1;
      if (doReq) reqPending <= 1'b1;
      else if (st.popReq) reqPending <= 1'b0;
    end
  end

  // Packet storage carries no reset: only valid slots are ever read out
  always_ff @(posedge clk) begin
    if (doWr)
      for (int b = 0; b < LONG_LEN; b++)
        slotMem[wrPtr][b] <= rplData[b*DATA_W +: DATA_W];
    if (doReq)
      for (int b = 0; b < SHORT_LEN; b++)
        reqMem[b] <= reqData[b*DATA_W +: DATA_W];
  end

  always_comb begin
    fifoBeat = '0;
    reqBeat  = '0;
    for (int b = 0; b < LONG_LEN; b++)
      if (beatIdx == IDX_W'(b)) fifoBeat = slotMem[rdPtr][b];
    for (int b = 0; b < SHORT_LEN; b++)
      if (beatIdx == IDX_W'(b)) reqBeat = reqMem[b];
  end

  assign busOut = !st.drive ? '0 : (st.selFifo ? fifoBeat : reqBeat);
endmodule

// File: rtl/pkt_bus_out_ctl.sv
module pkt_bus_out_ctl
  import pkt_bus_out_pkg::*;
#(
  parameter int LONG_LEN  = 5,
  parameter int SHORT_LEN = 2,
  localparam int IDX_W    = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic             headLong,
  input  logic             reqPending,
  input  logic             grant,
  input  logic             longGrant,
  output strobe_t          st,
  output logic [IDX_W-1:0] beatIdx,
  output logic [1:0]       arbReq
);
  seq_state_t state;
  logic       selFifo, pktLong, lastBeat;

  assign lastBeat = (beatIdx == (pktLong ? IDX_W'(LONG_LEN - 1) : IDX_W'(SHORT_LEN - 1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selFifo <= 1'b0;
      pktLong <= 1'b0;
      beatIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          // Replies are chosen ahead of the buffered request
          if (!fifoEmpty) begin
            selFifo <= 1'b1;
            pktLong <= headLong;
            state   <= ST_WAIT;
          end else if (reqPending) begin
            selFifo <= 1'b0;
            pktLong <= 1'b0;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (grant && (longGrant == pktLong)) begin
            beatIdx <= '0;
            state   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (lastBeat) state <= ST_IDLE;
          else beatIdx <= beatIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    st.drive   = (state == ST_SEND);
    st.header  = st.drive && (beatIdx == '0);
    st.selFifo = selFifo;
    st.popFifo = st.drive && lastBeat && selFifo;
    st.popReq  = st.drive && lastBeat && !selFifo;
    arbReq     = (state == ST_IDLE) ? 2'b00 : {1'b1, pktLong};
  end
endmodule

// File: rtl/pkt_bus_out.sv
module pkt_bus_out
  import pkt_bus_out_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LONG_LEN  = 5,
  parameter int SHORT_LEN = 2,
  parameter int SLOTS     = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqPush,
  input  logic [SHORT_LEN*DATA_W-1:0] reqData,
  input  logic                        rplPush,
  input  logic                        rplLong,
  input  logic [LONG_LEN*DATA_W-1:0]  rplData,
  input  logic                        grant,
  input  logic                        longGrant,
  output logic [1:0]                  arbReq,
  output logic [DATA_W-1:0]           busOut,
  output logic                        busOutEn,
  output logic                        headerOut,
  output logic                        stopOut
);
  localparam int IDX_W = $clog2(LONG_LEN);

  strobe_t          st;
  logic [IDX_W-1:0] beatIdx;
  logic             fifoEmpty, headLong, reqPending;

  pkt_bus_out_ctl #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .headLong(headLong),
    .reqPending(reqPending), .grant(grant), .longGrant(longGrant),
    .st(st), .beatIdx(beatIdx), .arbReq(arbReq)
  );

  pkt_bus_out_dp #(.DATA_W(DATA_W), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN),
                   .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .reqPush(reqPush), .reqData(reqData),
    .rplPush(rplPush), .rplLong(rplLong), .rplData(rplData), .st(st),
    .beatIdx(beatIdx), .fifoEmpty(fifoEmpty), .headLong(headLong),
    .reqPending(reqPending), .busOut(busOut), .stopOut(stopOut)
  );

  assign busOutEn  = st.drive;
  assign headerOut = st.header;
endmodule

// File: rtl/pkt_bus_out_chk.sv
module pkt_bus_out_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              grant,
  input logic              longGrant,
  input logic [1:0]        arbReq,
  input logic [DATA_W-1:0] busOut,
  input logic              busOutEn,
  input logic              headerOut,
  input logic              stopOut
);
  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busOutEn |-> busOut == '0);
  p_no_hold_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    arbReq != 2'b01);
  p_code_while_send_r2: assert property (@(posedge clk) disable iff (!rstN)
    busOutEn |-> arbReq[1]);
  p_send_after_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOutEn) |-> $past(grant));
  p_grant_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOutEn) |-> ($past(longGrant) == arbReq[0]));
  p_header_in_packet_r5: assert property (@(posedge clk) disable iff (!rstN)
    headerOut |-> busOutEn);
  p_header_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    headerOut |=> !headerOut);
  p_stop_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopOut |=> stopOut);
endmodule

bind pkt_bus_out pkt_bus_out_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_pkt_bus_out.sv
module tb_pkt_bus_out;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqPush = 1'b0, rplPush = 1'b0, rplLong = 1'b0;
  logic [127:0] reqData = '0;
  logic [319:0] rplData = '0;
  logic         grant = 1'b0, longGrant = 1'b0;
  logic [1:0]   arbReq;
  logic [63:0]  busOut;
  logic         busOutEn, headerOut, stopOut;
  int           nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  pkt_bus_out dut (.*);

  function automatic logic [63:0] beatVal(input logic [7:0] tag, input int i);
    return {24'hC0FFEE, tag, 32'(i)};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) tick();
    check(arbReq == 2'b00 && !busOutEn && !headerOut && !stopOut && busOut == '0,
          "R1", "outputs in reset", {arbReq, busOutEn, headerOut, stopOut}, '0);
    rstN = 1'b1;
    tick();
    check(arbReq == 2'b00 && !busOutEn && !stopOut && busOut == '0,
          "R1", "outputs after reset", {arbReq, busOutEn, stopOut}, '0);
  endtask

  task automatic pushRpl(input logic [7:0] tag, input bit isLong);
    for (int b = 0; b < 5; b++) rplData[b*64 +: 64] = beatVal(tag, b);
    rplLong = isLong; rplPush = 1'b1;
    tick();
    rplPush = 1'b0;
  endtask

  task automatic pushReq(input logic [7:0] tag);
    for (int b = 0; b < 2; b++) reqData[b*64 +: 64] = beatVal(tag, b);
    reqPush = 1'b1;
    tick();
    reqPush = 1'b0;
  endtask

  // Wait for a request, grant it and compare every beat of the packet
  task automatic sendPkt(input logic [7:0] tag, input bit isLong, input string rq);
    int len = isLong ? 5 : 2;
    for (int w = 0; w < 8 && arbReq == 2'b00; w++) tick();
    check(arbReq == {1'b1, isLong}, rq, "request code", 64'(arbReq), 64'({1'b1, isLong}));
    grant = 1'b1; longGrant = isLong;
    tick();
    grant = 1'b0; longGrant = 1'b0;
    for (int i = 0; i < len; i++) begin
      check(busOutEn && busOut == beatVal(tag, i), rq, "R4 beat data",
            busOut, beatVal(tag, i));
      check(headerOut == (i == 0), rq, "R5 header flag", 64'(headerOut), 64'(i == 0));
      tick();
    end
    check(!busOutEn && arbReq == 2'b00, rq, "R6 release after last beat",
          {arbReq, busOutEn}, '0);
  endtask

  task automatic testBasic();
    pushRpl(8'h11, 1'b1);
    sendPkt(8'h11, 1'b1, "R2 long reply");
    pushReq(8'h22);
    sendPkt(8'h22, 1'b0, "R2 short request");
  endtask

  task automatic testWrongGrant();
    pushRpl(8'h33, 1'b1);
    repeat (2) tick();
    grant = 1'b1; longGrant = 1'b0;
    tick();
    grant = 1'b0;
    check(!busOutEn && arbReq == 2'b11, "R3", "short grant for long packet",
          {arbReq, busOutEn}, {2'b11, 1'b0});
    tick();
    check(!busOutEn, "R3", "still idle on bus", 64'(busOutEn), 0);
    sendPkt(8'h33, 1'b1, "R3 matching grant");
  endtask

  task automatic testPriority();
    for (int b = 0; b < 2; b++) reqData[b*64 +: 64] = beatVal(8'h44, b);
    for (int b = 0; b < 5; b++) rplData[b*64 +: 64] = beatVal(8'h55, b);
    reqPush = 1'b1; rplPush = 1'b1; rplLong = 1'b0;
    tick();
    reqPush = 1'b0; rplPush = 1'b0;
    sendPkt(8'h55, 1'b0, "R7 FIFO first");
    sendPkt(8'h44, 1'b0, "R7 request second");
  endtask

  task automatic testOrder();
    pushRpl(8'h61, 1'b1);
    pushRpl(8'h62, 1'b0);
    pushRpl(8'h63, 1'b1);
    sendPkt(8'h61, 1'b1, "R8 R11 first long");
    sendPkt(8'h62, 1'b0, "R8 R11 short");
    sendPkt(8'h63, 1'b1, "R8 R11 second long");
  endtask

  task automatic testReqBusy();
    pushReq(8'h71);
    pushReq(8'h72);
    sendPkt(8'h71, 1'b0, "R9 first request");
    repeat (4) tick();
    check(arbReq == 2'b00, "R9", "second request dropped", 64'(arbReq), 0);
  endtask

  task automatic testOverflow();
    for (int k = 0; k < 4; k++) pushRpl(8'h80 + 8'(k), 1'b0);
    check(!stopOut, "R10", "stop while filling", 64'(stopOut), 0);
    pushRpl(8'h8F, 1'b1);
    check(stopOut, "R10", "stop on overflow", 64'(stopOut), 1);
    for (int k = 0; k < 4; k++) sendPkt(8'h80 + 8'(k), 1'b0, "R10 drain");
    repeat (4) tick();
    check(arbReq == 2'b00, "R10", "overflowed packet dropped", 64'(arbReq), 0);
    check(stopOut, "R10", "stop sticky", 64'(stopOut), 1);
    doReset();
    check(!stopOut, "R10", "stop cleared by reset", 64'(stopOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #1;
    doReset();
    testBasic();
    testWrongGrant();
    testPriority();
    testOrder();
    testReqBusy();
    testOverflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule